// File: doc/BRIEF.md
# Register-Mapped 32-bit Unsigned Divider

This peripheral divides a 32-bit unsigned dividend by a 32-bit unsigned divisor on behalf of software. Software reaches it through a small register bus of 16-bit locations. It loads the dividend and the divisor as 16-bit halves, in any order. It then writes the control register with the division-mode bit and the start bit both set.

The block then runs an iterative radix-4 restoring division and retires two quotient bits every clock, so a full division takes 16 clocks. When it finishes, the quotient replaces the dividend in its own register pair and the remainder lands in a separate read-only result pair. The start bit drops back to zero, so software can poll it as a busy flag. Unless the control register's quiet bit is set, a one-cycle interrupt pulse also marks the finish.

All register contents persist between runs. Software can therefore relaunch a division on the current contents by writing the start bit alone.

Top module: `mdiv_unit`

## Requirements
- R1: After reset, every register location reads 0 and `done_irq` is low.
- R2: Locations 0/1 hold the low/high half of the dividend (A), and 2/3 hold the low/high half of the divisor (B). They are writable in any order and read back what was written while the block is idle.
- R3: Location 6 is the control register, held in bits 7:0 of the bus word. Bit 7 selects division mode, bit 3 is the quiet bit and bit 0 is start. Bits 7:1 read back as written. A write with bit 0 set starts a division only if bit 7 is also set in the same write; otherwise bit 0 reads 0 and nothing runs.
- R4: A starting write accepted at clock edge E0 makes control bit 0 read 1 from E0 up to, but not including, edge E0+16. After edge E0+16 it reads 0.
- R5: After completion, A holds floor(dividend/divisor) and locations 4/5 (C, low/high, read-only) hold the remainder, which is below the divisor.
- R6: A zero divisor gives a quotient of 0xFFFFFFFF and a remainder equal to the dividend, with the same 16-clock timing.
- R7: `done_irq` is high for exactly the one cycle after edge E0+16 when the quiet bit is 0. It stays low when the quiet bit is 1.
- R8: The mode bits and B are kept after a run. Writing start again (0x81) divides the current A (the previous quotient) by the current B.
- R9: While a division is running, writes to any location are ignored, including a second start. The result and the finish time are those of the original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register location |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed location, combinational |
| done_irq | output | 1 | Completion interrupt pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit data width and two quotient bits per step. This gives 16 steps, three divisor multiples compared per step and a 16-bit bus. These values bring within reach the exact 16-clock finish, carries across both register halves, and all-ones operands where the partial remainder needs its two extra bits. Zero, unit and oversized divisors exercise the digit-3, zero-divisor override and all-digit-0 paths.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] LOC_A_LO = 3'd0;
    localparam logic [ADDR_W-1:0] LOC_A_HI = 3'd1;
    localparam logic [ADDR_W-1:0] LOC_B_LO = 3'd2;
    localparam logic [ADDR_W-1:0] LOC_B_HI = 3'd3;
    localparam logic [ADDR_W-1:0] LOC_C_LO = 3'd4;
    localparam logic [ADDR_W-1:0] LOC_C_HI = 3'd5;
    localparam logic [ADDR_W-1:0] LOC_CTRL = 3'd6;

    localparam int CTRL_W      = 8;
    localparam int BIT_START   = 0;
    localparam int BIT_QUIET   = 3;
    localparam int BIT_DIVMODE = 7;
endpackage

// File: rtl/mdiv_step.sv
module mdiv_step #(
    parameter int W  = 32,
    parameter int DB = 2
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] div_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    localparam int RW = W + DB;
    localparam int NM = (1 << DB) - 1;

    logic [RW-1:0] trial;
    logic [RW-1:0] mult [1:NM];
    logic [NM-1:0] fits;
    logic [DB-1:0] digit;
    logic [W-1:0]  sub;

    assign trial = {rem_i, quo_i[W-1 -: DB]};

    // one comparator per divisor multiple; fits is thermometer coded
    for (genvar k = 1; k <= NM; k++) begin : g_mult
        assign mult[k]   = RW'(div_i) * RW'(k);
        assign fits[k-1] = (trial >= mult[k]);
    end

    always_comb begin
        digit = '0;
        for (int j = 0; j < NM; j++) begin
            if (fits[j]) digit = digit + DB'(1);
        end
        sub = '0;
        for (int j = 1; j <= NM; j++) begin
            if (digit == DB'(j)) sub = mult[j][W-1:0];
        end
    end

    assign rem_o = trial[W-1:0] - sub;
    assign quo_o = {quo_i[W-DB-1:0], digit};
endmodule

// File: rtl/mdiv_ctrl.sv
module mdiv_ctrl #(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o
);
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.busy) begin
            if (last_o) begin
                seq_d.busy = 1'b0;
                seq_d.cnt  = '0;
            end else begin
                seq_d.cnt = seq_q.cnt + CNT_W'(1);
            end
        end else if (start_i) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;
    assign last_o = seq_q.busy && (seq_q.cnt == CNT_W'(STEPS - 1));

    AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !busy_o); // R4
endmodule

// File: rtl/mdiv_unit.sv
module mdiv_unit
    import mdiv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIGIT  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W/2-1:0] bus_wdata,
    output logic [DATA_W/2-1:0] bus_rdata,
    output logic                done_irq
);
    localparam int HALF_W = DATA_W / 2;
    localparam int STEPS  = DATA_W / DIGIT;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] c;
        logic [DATA_W-1:0] quo;
        logic [CTRL_W-1:1] ctrl;
        logic              irq;
    } regs_t;

    regs_t r_d, r_q;
    logic busy, last, start, wr_ok, zero_div;
    logic [DATA_W-1:0] step_rem, step_quo;

    mdiv_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .last_o(last)
    );

    mdiv_step #(.W(DATA_W), .DB(DIGIT)) u_step (
        .rem_i(r_q.c), .quo_i(r_q.quo), .div_i(r_q.b),
        .rem_o(step_rem), .quo_o(step_quo)
    );

    assign wr_ok    = bus_wr && !busy;
    assign start    = wr_ok && (bus_addr == LOC_CTRL) &&
                      bus_wdata[BIT_START] && bus_wdata[BIT_DIVMODE];
    assign zero_div = (r_q.b == '0);

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        if (wr_ok) begin
            case (bus_addr)
                LOC_A_LO: r_d.a[HALF_W-1:0]      = bus_wdata;
                LOC_A_HI: r_d.a[DATA_W-1:HALF_W] = bus_wdata;
                LOC_B_LO: r_d.b[HALF_W-1:0]      = bus_wdata;
                LOC_B_HI: r_d.b[DATA_W-1:HALF_W] = bus_wdata;
                LOC_CTRL: r_d.ctrl               = bus_wdata[CTRL_W-1:1];
                default: ;
            endcase
        end
        if (start) begin
            r_d.c   = '0;
            r_d.quo = r_q.a;
        end
        if (busy) begin
            r_d.c   = step_rem;
            r_d.quo = step_quo;
            if (last) begin
                r_d.a   = zero_div ? '1 : step_quo;
                r_d.c   = zero_div ? r_q.a : step_rem;
                r_d.irq = !r_q.ctrl[BIT_QUIET];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            LOC_A_LO: bus_rdata = r_q.a[HALF_W-1:0];
            LOC_A_HI: bus_rdata = r_q.a[DATA_W-1:HALF_W];
            LOC_B_LO: bus_rdata = r_q.b[HALF_W-1:0];
            LOC_B_HI: bus_rdata = r_q.b[DATA_W-1:HALF_W];
            LOC_C_LO: bus_rdata = r_q.c[HALF_W-1:0];
            LOC_C_HI: bus_rdata = r_q.c[DATA_W-1:HALF_W];
            LOC_CTRL: bus_rdata = HALF_W'({r_q.ctrl, busy});
            default:  bus_rdata = '0;
        endcase
    end

    assign done_irq = r_q.irq;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq); // R7
    AST_IRQ_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!busy && $past(busy))); // R4
    AST_QUIET_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !r_q.ctrl[BIT_QUIET]); // R7
    AST_DIVISOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(r_q.b)); // R9
    AST_DIVIDEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(r_q.a)); // R9
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !zero_div) |-> (r_q.c < r_q.b)); // R5
endmodule

// File: tb/mdiv_unit_bench.sv
module mdiv_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        done_irq;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    mdiv_unit u_mdiv_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_irq(done_irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            total++; fails++;
            $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 100000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd32(logic [2:0] lo, output logic [31:0] d);
        logic [15:0] l, h;
        rd(lo, l);
        rd(lo + 3'd1, h);
        d = {h, l};
    endtask

    // start with control value cv; poll busy and irq on every negedge
    task automatic start_run(string req, logic [7:0] cv, bit exp_irq, bit poke);
        logic [15:0] v;
        wr(3'd6, {8'h00, cv});
        for (int i = 0; i <= 16; i++) begin
            if (i > 0) @(negedge clk);
            bus_wr = 1'b0;
            bus_addr = 3'd6;
            #1 v = bus_rdata;
            if (i == 0 || i == 15 || i == 16)
                chk({req, " R4 busy bit"}, {31'd0, v[0]}, (i < 16) ? 32'd1 : 32'd0);
            if (i == 15 || i == 16)
                chk({req, " R7 irq"}, {31'd0, done_irq},
                    (i == 16 && exp_irq) ? 32'd1 : 32'd0);
            if (poke && i >= 2 && i <= 4) begin
                bus_wr = 1'b1;
                bus_addr = (i == 2) ? 3'd2 : (i == 3) ? 3'd0 : 3'd6;
                bus_wdata = (i == 4) ? 16'h0081 : 16'h5A5A;
            end
        end
        @(negedge clk);
        #1 chk({req, " R7 irq width"}, {31'd0, done_irq}, 32'd0);
    endtask

    task automatic check_result(string req, logic [31:0] dd, logic [31:0] dv);
        logic [31:0] q, r, bq, eq, er;
        eq = (dv == 0) ? 32'hFFFF_FFFF : dd / dv;
        er = (dv == 0) ? dd : dd % dv;
        rd32(3'd0, q);
        rd32(3'd4, r);
        rd32(3'd2, bq);
        chk({req, " quotient"}, q, eq);
        chk({req, " remainder"}, r, er);
        chk({req, " R8 divisor kept"}, bq, dv);
    endtask

    task automatic load(logic [31:0] dd, logic [31:0] dv);
        wr(3'd0, dd[15:0]); wr(3'd1, dd[31:16]);
        wr(3'd2, dv[15:0]); wr(3'd3, dv[31:16]);
    endtask

    task automatic divide(string req, logic [31:0] dd, logic [31:0] dv);
        load(dd, dv);
        start_run(req, 8'h81, 1'b1, 1'b0);
        check_result(req, dd, dv);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1 reset read", {16'd0, v}, 32'd0);
        end
        chk("R1 reset irq", {31'd0, done_irq}, 32'd0);
    endtask

    task automatic t_operands();
        logic [31:0] v;
        wr(3'd3, 16'hBEEF); wr(3'd0, 16'h1234); wr(3'd2, 16'hCAFE); wr(3'd1, 16'h8765);
        rd32(3'd0, v); chk("R2 dividend halves", v, 32'h8765_1234);
        rd32(3'd2, v); chk("R2 divisor halves", v, 32'hBEEF_CAFE);
    endtask

    task automatic t_mode();
        logic [15:0] v;
        logic [31:0] a;
        wr(3'd6, 16'h0001);
        repeat (3) @(negedge clk);
        rd(3'd6, v);
        chk("R3 start without mode", {16'd0, v}, 32'd0);
        chk("R3 no irq", {31'd0, done_irq}, 32'd0);
        rd32(3'd0, a);
        chk("R3 dividend untouched", a, 32'h8765_1234);
        wr(3'd6, 16'h0080);
        rd(3'd6, v);
        chk("R3 mode readback", {16'd0, v}, 32'h80);
    endtask

    task automatic t_edges();
        divide("R5 small", 32'd100, 32'd7);
        divide("R5 divisor one", 32'hDEAD_BEEF, 32'd1);
        divide("R5 divisor larger", 32'd5, 32'd9);
        divide("R5 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        divide("R5 ones by three", 32'hFFFF_FFFF, 32'd3);
        divide("R5 zero dividend", 32'd0, 32'd17);
        divide("R6 zero divisor", 32'h1357_9BDF, 32'd0);
    endtask

    task automatic t_random();
        for (int n = 0; n < 12; n++) begin
            logic [31:0] dd, dv;
            dd = $urandom;
            dv = $urandom >> (n * 2);
            divide("R5 random", dd, dv);
        end
    endtask

    task automatic t_quiet();
        logic [15:0] v;
        load(32'd1000, 32'd33);
        start_run("R7 quiet", 8'h89, 1'b0, 1'b0);
        check_result("R7 quiet", 32'd1000, 32'd33);
        rd(3'd6, v);
        chk("R8 mode kept", {16'd0, v}, 32'h88);
        wr(3'd6, 16'h0080);
    endtask

    task automatic t_restart();
        logic [15:0] v;
        load(32'd1_000_000, 32'd7);
        start_run("R8 first", 8'h81, 1'b1, 1'b0);
        start_run("R8 restart", 8'h81, 1'b1, 1'b0);
        check_result("R8 restart", 32'd1_000_000 / 7, 32'd7);
        rd(3'd6, v);
        chk("R8 ctrl kept", {16'd0, v}, 32'h80);
    endtask

    task automatic t_busy_writes();
        load(32'h0F0F_0F0F, 32'd255);
        start_run("R9 busy writes", 8'h81, 1'b1, 1'b1);
        check_result("R9 busy writes", 32'h0F0F_0F0F, 32'd255);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_operands();
        t_mode();
        t_edges();
        t_random();
        t_quiet();
        t_restart();
        t_busy_writes();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule